// File: doc/BRIEF.md
# Peripheral Clock Select, Divide and Gate

This block derives slow peripheral timing from one fast reference clock without making any new clock nets. Three candidate sources arrive as enable streams in the reference domain, each a one-cycle pulse per source period. A 32-bit control word picks one of them, sets an integer divisor, and opens up to two output gates. The block counts pulses of the chosen source and emits a single-cycle enable each time the count completes a period. Each gate passes that enable to its own output.

Software writes the control word through a single write strobe. Divisor and source changes are held back until the running period completes, so a reprogrammed divider never emits a shortened period. Gate bits act on the next divided pulse. The counter keeps running while both gates are closed, so reopening a gate does not shift the pulse phase. Instances that need only one output set a parameter that removes the second gate.

Top module: `pclk_seldiv`

## Requirements
- R1: After reset the control state is source select code 0, divisor 1 and both gates closed. Both outputs stay low until a gate is opened, and the first divided pulse after reset uses divisor 1.
- R2: The select code sits in control bits [5:4]. Codes 0 and 1 select `src_tick[0]`, code 2 selects `src_tick[1]` and code 3 selects `src_tick[2]`.
- R3: The divisor N sits in control bits [13:8]. Every N-th pulse of the selected source yields a divided pulse. The gated output is high for exactly the one reference cycle after the edge that sampled that source pulse.
- R4: A divisor field of 0 acts as 1: every selected source pulse yields a divided pulse.
- R5: Control bit 0 opens output `out_tick[0]`. While that bit is clear, `out_tick[0]` is held low.
- R6: Control bit 1 opens output `out_tick[1]`. While that bit is clear, `out_tick[1]` is held low. With parameter `GATE1_EN` = 0, `out_tick[1]` is always low.
- R7: The divider counts whether or not the gates are open. Opening a gate part way through a period yields its first pulse at that period's normal end.
- R8: A newly written select code or divisor is applied only when the running divided period completes. The period in progress finishes with the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word: gates [1:0], select [5:4], divisor [13:8] |
| src_tick | input | 3 | Enable streams of the three candidate sources |
| out_tick | output | 2 | Gated divided enables, one per gate |

## Verification
The sweep runs every select code against every divisor in a set that includes 0, 1, 63 and several small values. Each gate combination is tried too. The three sources tick at rates of every cycle, every second cycle and every third cycle. Because the rates differ, a wrong source mapping or a wrong divisor changes the cycle-exact pulse train. Each configuration is written while the previous one is still mid-period, which shows whether changes wait for the period boundary. A gate toggle part way through each run shows whether the counter phase survives closed gates. A final phase uses pseudo-random source streams and control words with small divisors, and includes divisor 0. A second instance built without the second gate runs on the same stimulus.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    parameter int CW_W    = 32;
    parameter int SEL_LSB = 4;
    parameter int SEL_W   = 2;
    parameter int DIV_LSB = 8;
    parameter int DIV_W   = 6;
    parameter int GATE_N  = 2;
    parameter int NSRC    = 3;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [DIV_W-1:0]  div;
        logic [GATE_N-1:0] gate;
    } cfg_t;

    localparam cfg_t CFG_RST = '{sel: '0, div: DIV_W'(1), gate: '0};

    // two select codes alias onto the first source
    function automatic logic [1:0] src_index(input logic [SEL_W-1:0] code);
        logic [1:0] idx;
        case (code)
            2'd2:    idx = 2'd1;
            2'd3:    idx = 2'd2;
            default: idx = 2'd0;
        endcase
        return idx;
    endfunction

    function automatic cfg_t unpack_word(input logic [CW_W-1:0] w);
        cfg_t c;
        c.sel  = w[SEL_LSB +: SEL_W];
        c.div  = w[DIV_LSB +: DIV_W];
        c.gate = w[GATE_N-1:0];
        return c;
    endfunction

endpackage

// File: rtl/pclk_cfg_reg.sv
module pclk_cfg_reg
    import pclk_pkg::*;
#(
    parameter bit GATE1_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CW_W-1:0] wr_data,
    output cfg_t            cfg_o
);

    typedef struct packed {
        cfg_t cfg;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cfg = unpack_word(wr_data);
            if (!GATE1_EN) begin
                st_d.cfg.gate[1] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg <= CFG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;

endmodule

// File: rtl/pclk_src_mux.sv
module pclk_src_mux
    import pclk_pkg::*;
(
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] code,
    output logic             sel_tick
);

    always_comb begin
        sel_tick = src_tick[src_index(code)];
    end

endmodule

// File: rtl/pclk_div_core.sv
module pclk_div_core
    import pclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  cfg_t             pend_i,
    output logic [SEL_W-1:0] act_sel_o,
    output logic [DIV_W-1:0] act_div_o,
    output logic [DIV_W-1:0] cnt_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [DIV_W-1:0] eff_div;
    logic             at_last;

    always_comb begin
        st_d    = st_q;
        eff_div = (st_q.div == '0) ? DIV_W'(1) : st_q.div;
        at_last = (st_q.cnt == eff_div - DIV_W'(1));
        wrap_o  = step_i && at_last;
        if (step_i) begin
            if (at_last) begin
                // period boundary: adopt pending settings
                st_d.cnt = '0;
                st_d.sel = pend_i.sel;
                st_d.div = pend_i.div;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel <= CFG_RST.sel;
            st_q.div <= CFG_RST.div;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_sel_o = st_q.sel;
    assign act_div_o = st_q.div;
    assign cnt_o     = st_q.cnt;

endmodule

// File: rtl/pclk_seldiv.sv
module pclk_seldiv
    import pclk_pkg::*;
#(
    parameter bit GATE1_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    input  logic [2:0]  src_tick,
    output logic [1:0]  out_tick
);

    cfg_t              cfg;
    logic [SEL_W-1:0]  act_sel;
    logic [DIV_W-1:0]  act_div;
    logic [DIV_W-1:0]  cnt;
    logic              wrap;
    logic              sel_tick;
    logic [GATE_N-1:0] gate_fire;

    typedef struct packed {
        logic [GATE_N-1:0] tick;
    } out_st_t;

    out_st_t st_d, st_q;

    pclk_cfg_reg #(.GATE1_EN(GATE1_EN)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg_o   (cfg)
    );

    pclk_src_mux mux_i (
        .src_tick (src_tick),
        .code     (act_sel),
        .sel_tick (sel_tick)
    );

    pclk_div_core div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (sel_tick),
        .pend_i    (cfg),
        .act_sel_o (act_sel),
        .act_div_o (act_div),
        .cnt_o     (cnt),
        .wrap_o    (wrap)
    );

    for (genvar g = 0; g < GATE_N; g++) begin : g_gate
        if (g == 1 && !GATE1_EN) begin : g_off
            assign gate_fire[g] = 1'b0;
        end else begin : g_on
            assign gate_fire[g] = wrap && cfg.gate[g];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.tick = gate_fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tick <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_tick = st_q.tick;

endmodule

// File: rtl/pclk_seldiv_chk.sv
module pclk_seldiv_chk
    import pclk_pkg::*;
#(
    parameter bit GATE1_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        out_tick,
    input logic [GATE_N-1:0] cfg_gate,
    input logic [SEL_W-1:0]  act_sel,
    input logic [DIV_W-1:0]  act_div,
    input logic [DIV_W-1:0]  cnt,
    input logic              wrap,
    input logic              sel_tick
);

    logic [DIV_W-1:0] lim;
    assign lim = (act_div == '0) ? DIV_W'(1) : act_div;

    AST_GATE0_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick[0] |-> $past(cfg_gate[0])); // R5

    AST_GATE1_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick[1] |-> $past(cfg_gate[1])); // R6

    AST_GATE1_REMOVED: assert property (@(posedge clk) disable iff (!rst_n)
        (!GATE1_EN) |-> !out_tick[1]); // R6

    AST_PULSE_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_tick) |-> ($past(sel_tick) && $past(wrap))); // R2

    AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < lim); // R3

    AST_DIV0_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div == '0) |-> (cnt == '0)); // R4

    AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_div) || !$stable(act_sel)) |-> $past(wrap)); // R8

endmodule

bind pclk_seldiv pclk_seldiv_chk #(.GATE1_EN(GATE1_EN)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_tick (out_tick),
    .cfg_gate (cfg.gate),
    .act_sel  (act_sel),
    .act_div  (act_div),
    .cnt      (cnt),
    .wrap     (wrap),
    .sel_tick (sel_tick)
);

// File: tb/pclk_seldiv_tb.sv
`timescale 1ns/1ps
module pclk_seldiv_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  src_tick = '0;
    logic [1:0]  out_a;
    logic [1:0]  out_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pclk_seldiv #(.GATE1_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .src_tick(src_tick), .out_tick(out_a)
    );

    pclk_seldiv #(.GATE1_EN(1'b0)) dut_nog1 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .src_tick(src_tick), .out_tick(out_b)
    );

    // behavioural expectation built from the requirements
    int   m_sel, m_div, m_gate;
    int   a_sel, a_div, m_cnt;
    logic [1:0] exp_out;
    string req;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int pick(input int code);
        return (code < 2) ? 0 : code - 1;
    endfunction

    task automatic check(input string r, input logic [1:0] got, input logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s ctrl sel=%0d div=%0d gate=%0d got=%b exp=%b",
                     r, m_sel, m_div, m_gate, got, exp);
        end
    endtask

    task automatic step(input logic we, input logic [31:0] wd, input logic [2:0] src);
        int ed;
        bit pulse;
        cfg_we    = we;
        cfg_wdata = wd;
        src_tick  = src;
        @(posedge clk);
        pulse = 1'b0;
        ed = (a_div == 0) ? 1 : a_div;
        if (src[pick(a_sel)]) begin
            if (m_cnt == ed - 1) begin
                pulse = 1'b1;
                m_cnt = 0;
                a_sel = m_sel;
                a_div = m_div;
            end else begin
                m_cnt++;
            end
        end
        exp_out[0] = pulse & m_gate[0];
        exp_out[1] = pulse & m_gate[1];
        if (we) begin
            m_sel  = (wd >> 4) & 3;
            m_div  = (wd >> 8) & 63;
            m_gate = wd & 3;
        end
        @(negedge clk);
        check(req, out_a, exp_out);
        // R6: instance without the second gate
        check({req, " R6"}, out_b, {1'b0, exp_out[0]});
    endtask

    function automatic logic [2:0] rate_src(input int t);
        return {(t % 3) == 0, (t % 2) == 0, 1'b1};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int t;
        int divs[7] = '{0, 1, 2, 3, 4, 7, 63};
        m_sel = 0; m_div = 1; m_gate = 0;
        a_sel = 0; a_div = 1; m_cnt = 0;
        t = 0;
        @(negedge clk);
        // R1: outputs low while reset is held, sources ticking
        src_tick = 3'b111;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R1 in reset", out_a, 2'b00);
        end
        rst_n = 1'b1;
        req = "R1";
        for (int i = 0; i < 10; i++) step(1'b0, '0, 3'b111);
        // R1: first boundary after reset uses divisor 1 although 5 is pending
        step(1'b1, 32'h0000_0503, 3'b000);
        step(1'b0, '0, 3'b001);

        // sweep: select codes (R2), divisors (R3, R4), gates (R5, R6, R7), R8
        req = "R2 R3 R4 R5 R6 R7 R8";
        for (int code = 0; code < 4; code++) begin
            for (int di = 0; di < 7; di++) begin
                for (int gs = 1; gs < 4; gs++) begin
                    logic [31:0] w;
                    w = (32'(divs[di]) << 8) | (32'(code) << 4) | 32'(gs);
                    step(1'b1, w, rate_src(t)); t++;
                    for (int k = 1; k < 200; k++) begin
                        if (k == 100) begin
                            // R7: gate change only, divider phase must persist
                            step(1'b1, w ^ 32'h3, rate_src(t));
                        end else begin
                            step(1'b0, '0, rate_src(t));
                        end
                        t++;
                    end
                end
            end
        end

        // pseudo-random sources and words with small divisors (R4, R8)
        req = "R4 R8 random";
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if ((k % 41) == 0) begin
                step(1'b1, {18'd0, 3'd0, lfsr[5:3], 2'd0, lfsr[9:8], 2'd0, lfsr[11:10]},
                     lfsr[2:0]);
            end else begin
                step(1'b0, '0, lfsr[2:0]);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule